// File: doc/BRIEF.md
# Power-of-Two Scaled Symmetric Quantizer

This block turns a vector of signed fixed-point values (weights, partial sums from split array tiles, or merged layer results) into narrow signed integer codes. It takes in the whole vector first and keeps it in a local store. While the elements arrive it tracks the largest magnitude. When the vector closes, it fixes one shared exponent `e`: the least value for which 2^e is at least that magnitude. In the second pass it reads the stored elements back in arrival order. Each one is scaled by 2^-e with a right shift and mapped onto a symmetric grid of ±(2^(k-1)-1) levels around zero.

A consumer rebuilds each value as 2^e × code / (2^(k-1)-1). For that reason every code is sent together with the exponent, with a two-bit class tag that follows the vector unchanged, and with a last-of-vector flag. Both sides use a valid/ready handshake. The block has a fill phase and an emit phase, and it never works on two vectors at once.

Top module: `qnt_pow2_quant`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: `out_exp` is the least e ≥ 0 for which 2^e ≥ max|x| over the vector. A vector whose peak magnitude is 0 or 1 gives e = 0.
- R3: Each code is sign(x) × floor(|x|·L/2^e + 1/2) with L = 2^(k-1)-1 (L = 127 at the default k = 8). Rounding is therefore half away from zero, and |x|·L is formed at full width before the shift.
- R4: No code is ever the two's-complement minimum (-128 at k = 8); every code lies in [-L, L]. An element equal to -2^e maps to -L.
- R5: Codes come out in the order their elements went in, one per handshake. `out_last` is 1 on the final code of the vector and only there.
- R6: `out_tag` equals the `in_tag` value sampled with the first element of the vector, and it stays the same for every code of that vector. The tag is 0 for weights, 1 for split-tile partials, 2 for merged outputs, and 3 is spare.
- R7: `in_ready` is 0 from the cycle after the closing element until the last code has been accepted. In that window an offered input is not taken. `in_ready` returns to 1 in the cycle after the final output handshake.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_code`, `out_exp`, `out_tag` and `out_last` hold their values.
- R9: A vector that reaches DEPTH elements with `in_last` still 0 is closed at its DEPTH-th element, as if `in_last` had been set there.
- R10: The most negative input, -2^(DATA_W-1), gives exponent DATA_W-1 and code -L. The most positive input in the same vector rounds to +L.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input element offered |
| in_ready | output | 1 | Block accepts an element (fill phase) |
| in_data | input | DATA_W | Signed two's-complement element |
| in_last | input | 1 | Element closes the vector |
| in_tag | input | 2 | Tensor class, sampled with the first element |
| out_valid | output | 1 | Code offered (emit phase) |
| out_ready | input | 1 | Consumer takes the code |
| out_code | output | CODE_W | Signed symmetric code |
| out_exp | output | $clog2(DATA_W) | Shared scale exponent of the vector |
| out_tag | output | 2 | Tensor class of the vector |
| out_last | output | 1 | Final code of the vector |

## Verification
The assertions assume that the consumer treats a code as taken only on a cycle where `out_valid` and `out_ready` are both high. They also assume that `in_data` carries a true two's-complement value, including the most negative one. Under those conditions the scale always covers the peak, so the saturation path should never fire. The stimulus drives inputs only on the falling edge and changes `in_valid` and `out_ready` only between edges. During the emit phase it offers input on purpose, so that the back-pressure checks see a real request being refused.

// File: rtl/qnt_pkg.sv
package qnt_pkg;
  typedef enum logic [1:0] {
    TAG_WEIGHT  = 2'd0,
    TAG_PARTIAL = 2'd1,
    TAG_MERGED  = 2'd2,
    TAG_SPARE   = 2'd3
  } tensor_tag_e;

  typedef enum logic {
    PH_FILL  = 1'b0,
    PH_DRAIN = 1'b1
  } phase_e;
endpackage

// File: rtl/qnt_peak_track.sv
module qnt_peak_track #(
  parameter int DATA_W = 16,
  parameter int EXP_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              upd,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] peak_q,
  output logic [DATA_W-1:0] peak_nx,
  output logic [EXP_W-1:0]  exp_nx
);
  function automatic logic [DATA_W-1:0] abs_val(logic [DATA_W-1:0] v);
    return v[DATA_W-1] ? (~v + 1'b1) : v;
  endfunction

  // least e with 2^e >= m; 0 and 1 both give 0
  function automatic logic [EXP_W-1:0] ceil_exp(logic [DATA_W-1:0] m);
    logic [EXP_W-1:0] e;
    e = '0;
    for (int i = 0; i < DATA_W; i++) begin
      if (m > (DATA_W'(1) << i)) e = EXP_W'(i + 1);
    end
    return e;
  endfunction

  logic [DATA_W-1:0] din_mag;

  always_comb begin
    din_mag = abs_val(din);
    peak_nx = (din_mag > peak_q) ? din_mag : peak_q;
    exp_nx  = ceil_exp(peak_nx);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      peak_q <= '0;
    else if (clr)    peak_q <= '0;
    else if (upd)    peak_q <= peak_nx;
  end

  assert_peak_covers_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !clr) |=> (peak_q >= $past(din_mag)));
endmodule

// File: rtl/qnt_vec_store.sv
module qnt_vec_store #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16,
  parameter int AW     = 4
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/qnt_code_map.sv
module qnt_code_map #(
  parameter int DATA_W = 16,
  parameter int CODE_W = 8,
  parameter int EXP_W  = 4
) (
  input  logic [DATA_W-1:0] din,
  input  logic [EXP_W-1:0]  shamt,
  output logic [CODE_W-1:0] code,
  output logic              sat_hit
);
  localparam int LEVELS = (1 << (CODE_W - 1)) - 1;
  localparam int PROD_W = DATA_W + CODE_W;

  function automatic logic [DATA_W-1:0] abs_val(logic [DATA_W-1:0] v);
    return v[DATA_W-1] ? (~v + 1'b1) : v;
  endfunction

  // full-width product, then half-up bias, then shift
  function automatic logic [PROD_W-1:0] round_shift(logic [DATA_W-1:0] m,
                                                    logic [EXP_W-1:0] s);
    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] bias;
    prod = PROD_W'(m) * PROD_W'(LEVELS);
    bias = (s == '0) ? '0 : (PROD_W'(1) << (s - 1'b1));
    return (prod + bias) >> s;
  endfunction

  logic [DATA_W-1:0] mag;
  logic [PROD_W-1:0] scaled;
  logic [CODE_W-1:0] q;

  always_comb begin
    mag     = abs_val(din);
    scaled  = round_shift(mag, shamt);
    sat_hit = scaled > PROD_W'(LEVELS);
    q       = sat_hit ? CODE_W'(LEVELS) : scaled[CODE_W-1:0];
    code    = din[DATA_W-1] ? (~q + 1'b1) : q;
  end
endmodule

// File: rtl/qnt_pow2_quant.sv
module qnt_pow2_quant #(
  parameter int DATA_W = 16,
  parameter int CODE_W = 8,
  parameter int DEPTH  = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [DATA_W-1:0]          in_data,
  input  logic                       in_last,
  input  logic [1:0]                 in_tag,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [CODE_W-1:0]          out_code,
  output logic [$clog2(DATA_W)-1:0]  out_exp,
  output logic [1:0]                 out_tag,
  output logic                       out_last
);
  import qnt_pkg::*;

  localparam int AW       = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int EXP_W    = $clog2(DATA_W);
  localparam int LEVELS   = (1 << (CODE_W - 1)) - 1;
  localparam logic [CODE_W-1:0] MIN_CODE = {1'b1, {(CODE_W-1){1'b0}}};

  phase_e             phase;
  logic [AW-1:0]      wr_cnt, rd_cnt, last_idx;
  logic [EXP_W-1:0]   exp_q;
  tensor_tag_e        tag_q;

  logic [DATA_W-1:0]  peak_q, peak_nx, rd_data;
  logic [EXP_W-1:0]   exp_nx;
  logic               sat_hit;

  // named events
  logic in_fire, out_fire, vec_close, vec_done, depth_full;

  assign in_ready   = (phase == PH_FILL);
  assign out_valid  = (phase == PH_DRAIN);
  assign in_fire    = in_valid && in_ready;
  assign out_fire   = out_valid && out_ready;
  assign depth_full = (wr_cnt == AW'(DEPTH - 1));
  assign vec_close  = in_fire && (in_last || depth_full);
  assign vec_done   = out_fire && (rd_cnt == last_idx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase    <= PH_FILL;
      wr_cnt   <= '0;
      rd_cnt   <= '0;
      last_idx <= '0;
      exp_q    <= '0;
      tag_q    <= TAG_WEIGHT;
    end else begin
      if (phase == PH_FILL) begin
        if (in_fire) begin
          if (wr_cnt == '0) tag_q <= tensor_tag_e'(in_tag);
          if (vec_close) begin
            phase    <= PH_DRAIN;
            last_idx <= wr_cnt;
            exp_q    <= exp_nx;
            rd_cnt   <= '0;
            wr_cnt   <= '0;
          end else begin
            wr_cnt <= wr_cnt + 1'b1;
          end
        end
      end else begin
        if (out_fire) begin
          if (vec_done) phase <= PH_FILL;
          else          rd_cnt <= rd_cnt + 1'b1;
        end
      end
    end
  end

  qnt_peak_track #(.DATA_W(DATA_W), .EXP_W(EXP_W)) u_peak (
    .clk(clk), .rst_n(rst_n), .clr(vec_done), .upd(in_fire),
    .din(in_data), .peak_q(peak_q), .peak_nx(peak_nx), .exp_nx(exp_nx)
  );

  qnt_vec_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW)) u_store (
    .clk(clk), .wr_en(in_fire), .wr_addr(wr_cnt), .wr_data(in_data),
    .rd_addr(rd_cnt), .rd_data(rd_data)
  );

  qnt_code_map #(.DATA_W(DATA_W), .CODE_W(CODE_W), .EXP_W(EXP_W)) u_map (
    .din(rd_data), .shamt(exp_q), .code(out_code), .sat_hit(sat_hit)
  );

  assign out_exp  = exp_q;
  assign out_tag  = tag_q;
  assign out_last = out_valid && (rd_cnt == last_idx);

  // exponent covers the peak and is the least such
  assert_exp_covers_R2: assert property (@(posedge clk) disable iff (!rst_n)
    vec_close |=> ((DATA_W+1)'(peak_q) <= ((DATA_W+1)'(1) << exp_q)));
  assert_exp_least_R2: assert property (@(posedge clk) disable iff (!rst_n)
    vec_close |=> (exp_q == '0 || peak_q > (DATA_W'(1) << (exp_q - 1'b1))));
  assert_no_min_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_code != MIN_CODE));
  assert_no_sat_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !sat_hit);
  assert_code_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($signed(out_code) <= LEVELS && $signed(out_code) >= -LEVELS));
  assert_close_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    vec_close |=> (out_valid && !in_ready));
  assert_done_reopens_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_fire && out_last) |=> (in_ready && !out_valid));
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_code) &&
      $stable(out_exp) && $stable(out_tag) && $stable(out_last)));
  assert_depth_cap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fire && depth_full) |=> out_valid);
endmodule

// File: tb/qnt_pow2_quant_tb.sv
`timescale 1ns/1ps
module qnt_pow2_quant_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_data = '0;
  logic        in_last = 1'b0;
  logic [1:0]  in_tag = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [7:0]  out_code;
  logic [3:0]  out_exp;
  logic [1:0]  out_tag;
  logic        out_last;

  int total = 0;
  int bad   = 0;
  int vec [0:31];

  always #10 clk = ~clk;

  qnt_pow2_quant dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .in_tag(in_tag),
    .out_valid(out_valid), .out_ready(out_ready), .out_code(out_code),
    .out_exp(out_exp), .out_tag(out_tag), .out_last(out_last)
  );

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_for(int n);
    int m = 0;
    int e = 0;
    for (int i = 0; i < n; i++) begin
      int a = (vec[i] < 0) ? -vec[i] : vec[i];
      if (a > m) m = a;
    end
    while ((64'(1) << e) < 64'(m)) e++;
    return e;
  endfunction

  // half away from zero: floor((2*|x|*127 + 2^e) / 2^(e+1))
  function automatic int code_for(int x, int e);
    longint a = (x < 0) ? -x : x;
    longint q = (2 * a * 127 + (longint'(1) << e)) / (longint'(1) << (e + 1));
    if (q > 127) q = 127;
    return (x < 0) ? -int'(q) : int'(q);
  endfunction

  task automatic send(int n, int tag, bit use_last, bit alt_tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      in_valid = 1'b1;
      in_data  = 16'(vec[i]);
      in_last  = use_last && (i == n - 1);
      in_tag   = (alt_tag && i > 0) ? 2'(~tag) : 2'(tag);
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  task automatic drain(int n, int tag, string req);
    int e = exp_for(n);
    out_ready = 1'b1;
    for (int i = 0; i < n; i++) begin
      check({req, " valid"}, int'(out_valid), 1);
      check({req, " code"}, int'($signed(out_code)), code_for(vec[i], e));
      check({req, " R2 exp"}, int'(out_exp), e);
      check({req, " R6 tag"}, int'(out_tag), tag);
      check({req, " R5 last"}, int'(out_last), int'(i == n - 1));
      @(negedge clk);
    end
    out_ready = 1'b0;
    check({req, " R7 ready back"}, int'(in_ready), 1);
    check({req, " R7 valid gone"}, int'(out_valid), 0);
  endtask

  task automatic t_reset();
    check("R1 out_valid", int'(out_valid), 0);
    check("R1 in_ready", int'(in_ready), 1);
  endtask

  task automatic t_mixed();   // R2 R3 R5
    vec[0] = 100; vec[1] = -37; vec[2] = 0; vec[3] = 55; vec[4] = -99;
    send(5, 1, 1'b1, 1'b0);
    drain(5, 1, "R3 mixed");
  endtask

  task automatic t_zero();    // R2 all-zero
    for (int i = 0; i < 4; i++) vec[i] = 0;
    send(4, 2, 1'b1, 1'b0);
    drain(4, 2, "R2 zeros");
  endtask

  task automatic t_ties();    // R3 ties, R4 at -2^e
    vec[0] = 2; vec[1] = 1; vec[2] = -1; vec[3] = -2;
    send(4, 0, 1'b1, 1'b0);
    drain(4, 0, "R4 ties");
  endtask

  task automatic t_extreme(); // R10
    vec[0] = -32768; vec[1] = 32767; vec[2] = 1; vec[3] = -1;
    send(4, 3, 1'b1, 1'b0);
    drain(4, 3, "R10 extreme");
  endtask

  task automatic t_stall();   // R7 R8
    int first;
    vec[0] = -300; vec[1] = 77; vec[2] = 511;
    send(3, 1, 1'b1, 1'b0);
    first = code_for(vec[0], exp_for(3));
    in_valid = 1'b1; in_data = 16'h4000; in_last = 1'b1;
    for (int k = 0; k < 4; k++) begin
      check("R7 blocked", int'(in_ready), 0);
      check("R8 held code", int'($signed(out_code)), first);
      check("R8 held valid", int'(out_valid), 1);
      @(negedge clk);
    end
    in_valid = 1'b0; in_last = 1'b0;
    drain(3, 1, "R7 stall");
  endtask

  task automatic t_cap();     // R9, R6 tag from first element
    for (int i = 0; i < 16; i++) vec[i] = i * 37 - 260;
    send(16, 2, 1'b0, 1'b1);
    drain(16, 2, "R9 cap");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mixed();
    t_zero();
    t_ties();
    t_extreme();
    t_stall();
    t_cap();
    t_mixed();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule